// File: doc/BRIEF.md
# Interval Timer with Watchdog

This block keeps a slow time base for a small controller and guards it with a watchdog. An 8-bit interval counter runs freely and cannot be stopped. It advances on one of eight prescaler tick enables, which are supplied from outside the block and chosen by a 3-bit rate select. The rates span 1/8 to 1/1024 of the oscillator. Each time the counter wraps, the block emits an interval interrupt pulse. That wrap is also the only event that advances a 6-bit watchdog counter.

The watchdog compares its count with a programmable 6-bit limit. When the limit is reached, it either requests a chip reset or, in timer mode, emits a watchdog interrupt. In both cases its count restarts from zero. Software writes two registers through a simple write port:

- Register 0 holds the rate select, the mode and a self-clearing interval-clear bit.
- Register 1 holds the limit and a self-clearing watchdog-clear bit.

Out of reset the watchdog is armed in reset mode with the longest limit, so it runs without any set-up write. Both counts are brought out for reading.

Top module: `interval_watchdog`

## Requirements
- R1: After a synchronous reset both counts are 0 and all three pulse outputs are low. The reset values are: rate select 7, reset mode on, limit 63.
- R2: Register 0 bits [2:0] select one tap. The interval count rises by one on each clock edge where `ps_tick[select]` is high. Ticks on the other taps have no effect.
- R3: Writing register 0 with bit 3 set makes the interval count 0 at that edge, even when the selected tap is high and the count is 255. No interval pulse is produced. The bit is not stored, and counting resumes on the next edge.
- R4: On a selected tick with the interval count at 255, the count becomes 0. At that same edge `itv_irq` goes high for exactly one cycle and the watchdog count rises by one.
- R5: Register 1 bits [5:0] hold the limit. A match is an interval overflow whose incremented watchdog count equals the limit, taken modulo 64. On a match the watchdog count becomes 0. A limit of 0 therefore matches every 64 overflows.
- R6: With register 0 bit 4 = 1 (reset mode), a match drives `rst_req` high for exactly one cycle and leaves `wd_irq` low.
- R7: With register 0 bit 4 = 0 (timer mode), a match drives `wd_irq` high for one cycle and never raises `rst_req`.
- R8: Writing register 1 with bit 6 set makes the watchdog count 0 at that edge. This takes priority over an interval overflow in the same cycle: that overflow neither advances the count nor matches.
- R9: With no register write after reset and the selected tap high every cycle, `rst_req` first rises at the 16128th clock edge after reset is released (63 × 256).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ps_tick | input | 8 | Prescaler tick enables, one per rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0: control register, 1: watchdog register |
| wr_data | input | 7 | Write data |
| itv_count | output | 8 | Interval counter value |
| wd_count | output | 6 | Watchdog counter value |
| itv_irq | output | 1 | Interval overflow pulse |
| wd_irq | output | 1 | Watchdog match pulse in timer mode |
| rst_req | output | 1 | Watchdog reset request pulse |

## Verification
Two events can land on the same edge: a software clear of a counter and the interval overflow that would advance or wrap it. The bench clears the interval counter and counts exactly 256 edges, so that its clear write falls on the overflow edge. It does this first with a watchdog-clear write and then with an interval-clear write. For the watchdog clear it checks that the watchdog count stays 0, that no match is produced even with a limit of 1, and that the next overflow 256 edges later does match. For the interval clear it checks that the count is 0, that no interval pulse appears and that the watchdog count is unchanged.

// File: rtl/ivwd_pkg.sv
package ivwd_pkg;
  // Register select on the write port
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_WDOG = 1'b1;

  // What a watchdog match does
  typedef enum logic {
    WD_AS_TIMER = 1'b0,
    WD_AS_RESET = 1'b1
  } wd_mode_e;
endpackage

// File: rtl/ivwd_regs.sv
module ivwd_regs
  import ivwd_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int WD_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [WD_W:0]    wr_data,
  output logic [SEL_W-1:0] sel_o,
  output wd_mode_e         mode_o,
  output logic [WD_W-1:0]  limit_o,
  output logic             itv_clr_o,
  output logic             wd_clr_o
);
  localparam int ITV_CLR_POS = SEL_W;
  localparam int MODE_POS    = SEL_W + 1;
  localparam int WD_CLR_POS  = WD_W;

  logic ctrl_wr, wdog_wr;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
  assign wdog_wr = wr_en && (wr_addr == ADDR_WDOG);

  // Clear bits are strobes: they act in the write cycle and are not stored.
  assign itv_clr_o = ctrl_wr && wr_data[ITV_CLR_POS];
  assign wd_clr_o  = wdog_wr && wr_data[WD_CLR_POS];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o   <= '1;
      mode_o  <= WD_AS_RESET;
      limit_o <= '1;
    end else begin
      if (ctrl_wr) begin
        sel_o  <= wr_data[SEL_W-1:0];
        mode_o <= wd_mode_e'(wr_data[MODE_POS]);
      end
      if (wdog_wr) begin
        limit_o <= wr_data[WD_W-1:0];
      end
    end
  end

  // The limit only changes through a write to the watchdog register (R5)
  assert_limit_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !wdog_wr |=> $stable(limit_o));
endmodule

// File: rtl/ivwd_interval.sv
module ivwd_interval #(
  parameter int TAPS  = 8,
  parameter int CNT_W = 8,
  localparam int SEL_W = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TAPS-1:0]  taps,
  input  logic [SEL_W-1:0] sel,
  input  logic             clr,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o,
  output logic             irq_o
);
  logic [TAPS-1:0] hit;
  logic            tick;

  // Tap selection: one comparator per tap, then an OR
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign hit[i] = taps[i] && (sel == SEL_W'(i));
  end
  assign tick = |hit;

  // A clear in the same cycle wins over the wrap
  assign ovf_o = tick && !clr && (count_o == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      irq_o <= ovf_o;
      if (clr)       count_o <= '0;
      else if (tick) count_o <= count_o + 1'b1;
    end
  end

  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count_o == '0));
  assert_flag_at_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (count_o == '0));
  assert_flag_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);
endmodule

// File: rtl/ivwd_watchdog.sv
module ivwd_watchdog
  import ivwd_pkg::*;
#(
  parameter int WD_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  input  logic            clr,
  input  logic [WD_W-1:0] limit,
  input  wd_mode_e        mode,
  output logic [WD_W-1:0] count_o,
  output logic            rst_req_o,
  output logic            irq_o
);
  logic [WD_W-1:0] nxt;
  logic            match;

  assign nxt   = count_o + 1'b1;
  assign match = adv && !clr && (nxt == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o   <= '0;
      rst_req_o <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      rst_req_o <= match && (mode == WD_AS_RESET);
      irq_o     <= match && (mode == WD_AS_TIMER);
      if (clr || match) count_o <= '0;
      else if (adv)     count_o <= nxt;
    end
  end

  assert_match_restarts_R5: assert property (@(posedge clk) disable iff (rst)
    (rst_req_o || irq_o) |-> (count_o == '0));
  assert_reset_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |=> !rst_req_o);
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr) |=> $stable(count_o));
  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count_o == '0 && !rst_req_o && !irq_o));
endmodule

// File: rtl/interval_watchdog.sv
module interval_watchdog
  import ivwd_pkg::*;
#(
  parameter int TAPS  = 8,
  parameter int CNT_W = 8,
  parameter int WD_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TAPS-1:0]  ps_tick,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [WD_W:0]    wr_data,
  output logic [CNT_W-1:0] itv_count,
  output logic [WD_W-1:0]  wd_count,
  output logic             itv_irq,
  output logic             wd_irq,
  output logic             rst_req
);
  localparam int SEL_W = $clog2(TAPS);

  logic [SEL_W-1:0] sel;
  wd_mode_e         mode;
  logic [WD_W-1:0]  limit;
  logic             itv_clr, wd_clr, ovf;

  ivwd_regs #(.SEL_W(SEL_W), .WD_W(WD_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sel_o(sel), .mode_o(mode), .limit_o(limit),
    .itv_clr_o(itv_clr), .wd_clr_o(wd_clr)
  );

  ivwd_interval #(.TAPS(TAPS), .CNT_W(CNT_W)) u_interval (
    .clk(clk), .rst(rst), .taps(ps_tick), .sel(sel), .clr(itv_clr),
    .count_o(itv_count), .ovf_o(ovf), .irq_o(itv_irq)
  );

  ivwd_watchdog #(.WD_W(WD_W)) u_watchdog (
    .clk(clk), .rst(rst), .adv(ovf), .clr(wd_clr), .limit(limit), .mode(mode),
    .count_o(wd_count), .rst_req_o(rst_req), .irq_o(wd_irq)
  );

  assert_one_action_R7: assert property (@(posedge clk) disable iff (rst)
    !(rst_req && wd_irq));
endmodule

// File: tb/interval_watchdog_tb.sv
module interval_watchdog_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] ps_tick;
  logic       wr_en;
  logic       wr_addr;
  logic [6:0] wr_data;
  logic [7:0] itv_count;
  logic [5:0] wd_count;
  logic       itv_irq, wd_irq, rst_req;

  int checks = 0;
  int fails  = 0;
  int n_rst  = 0;
  bit done   = 1'b0;

  logic [7:0] tick_all  = 8'hFF;
  logic [7:0] tick_slow = 8'h00;
  logic [1:0] phase     = 2'd0;

  always #10 clk = ~clk;

  interval_watchdog u_dut (
    .clk(clk), .rst(rst), .ps_tick(ps_tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .itv_count(itv_count), .wd_count(wd_count),
    .itv_irq(itv_irq), .wd_irq(wd_irq), .rst_req(rst_req)
  );

  // Tick pattern and reset-request counter, updated away from the active edge
  always @(negedge clk) begin
    if (rst_req) n_rst = n_rst + 1;
    phase   = phase + 2'd1;
    ps_tick = tick_all | ((phase == 2'd0) ? tick_slow : 8'h00);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Starts and ends at a falling edge; the write lands on the rising edge between
  task automatic wr(input logic a, input logic [6:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;  // R1
    chk("R1 itv_count", itv_count, 0);
    chk("R1 wd_count", wd_count, 0);
    chk("R1 pulses", {itv_irq, wd_irq, rst_req}, 0);
  endtask

  task automatic t_autostart;  // R9, R6, R1
    int n = 0;
    rst = 1'b0;
    while (n < 20000) begin
      @(negedge clk); n++;
      if (rst_req) break;
    end
    chk("R9 edges to reset request", n, 16128);
    chk("R6 no wd_irq in reset mode", wd_irq, 0);
    @(negedge clk);
    chk("R6 reset request one cycle", rst_req, 0);
    chk("R5 count restarts", wd_count, 0);
  endtask

  task automatic t_clear;  // R3
    wr(1'b0, 7'h08);
    chk("R3 cleared", itv_count, 0);
    @(negedge clk);
    chk("R3 clear self-clears", itv_count, 1);
  endtask

  task automatic t_rate;  // R2
    tick_all = 8'hFB; tick_slow = 8'h04;
    wr(1'b0, 7'h0A);
    repeat (40) @(negedge clk);
    chk("R2 tap 2 only", itv_count, 10);
    tick_all = 8'hFF; tick_slow = 8'h00;
    wr(1'b0, 7'h08);
    repeat (20) @(negedge clk);
    chk("R2 tap 0", itv_count, 20);
  endtask

  task automatic t_overflow;  // R4
    wr(1'b1, 7'h7F);
    wr(1'b0, 7'h08);
    repeat (255) @(negedge clk);
    chk("R4 count 255", itv_count, 255);
    chk("R4 no early pulse", itv_irq, 0);
    @(negedge clk);
    chk("R4 wrap", itv_count, 0);
    chk("R4 pulse", itv_irq, 1);
    chk("R4 watchdog advance", wd_count, 1);
    @(negedge clk);
    chk("R4 pulse one cycle", itv_irq, 0);
  endtask

  task automatic t_timer;  // R7, R5
    int r0 = n_rst;
    wr(1'b1, 7'h43);
    wr(1'b0, 7'h08);
    repeat (767) @(negedge clk);
    chk("R7 before match", wd_irq, 0);
    chk("R5 count before match", wd_count, 2);
    @(negedge clk);
    chk("R7 wd_irq", wd_irq, 1);
    chk("R5 count cleared", wd_count, 0);
    chk("R7 no reset request", n_rst - r0, 0);
  endtask

  task automatic t_coincide;  // R8, R3
    wr(1'b1, 7'h41);
    wr(1'b0, 7'h08);
    repeat (255) @(negedge clk);
    wr(1'b1, 7'h41);  // lands on the overflow edge
    chk("R8 count held at 0", wd_count, 0);
    chk("R8 no match", wd_irq, 0);
    chk("R4 interval still wraps", itv_irq, 1);
    repeat (256) @(negedge clk);
    chk("R8 next overflow matches", wd_irq, 1);
    wr(1'b0, 7'h08);
    repeat (255) @(negedge clk);
    wr(1'b0, 7'h08);  // lands where 255 would wrap
    chk("R3 clear over wrap", itv_count, 0);
    chk("R3 no pulse", itv_irq, 0);
    chk("R3 watchdog untouched", wd_count, 0);
  endtask

  task automatic t_limit0;  // R5
    int n = 0;
    wr(1'b1, 7'h40);
    wr(1'b0, 7'h08);
    while (n < 20000) begin
      @(negedge clk); n++;
      if (wd_irq) break;
    end
    chk("R5 limit 0 = 64 overflows", n, 16384);
  endtask

  task automatic t_resetmode;  // R6
    wr(1'b1, 7'h42);
    wr(1'b0, 7'h18);
    repeat (511) @(negedge clk);
    chk("R6 before match", rst_req, 0);
    @(negedge clk);
    chk("R6 reset request", rst_req, 1);
    chk("R6 no wd_irq", wd_irq, 0);
    @(negedge clk);
    chk("R6 one cycle", rst_req, 0);
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0; ps_tick = 8'hFF;
    repeat (3) @(negedge clk);
    t_reset();
    t_autostart();
    t_clear();
    t_rate();
    t_overflow();
    t_timer();
    t_coincide();
    t_limit0();
    t_resetmode();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule